// File: doc/BRIEF.md
# Serial Port FIFO Control with Transmit Trigger Flag

This block holds the two data buffers of a serial port and the control register that governs them. A byte-wide transmit FIFO and a byte-wide receive FIFO, 16 entries each, are filled and drained through push and pop strobes. Both occupancy counts are visible at the ports. An 8-bit control register, written and read through a simple register port, does four things. It selects one of four transmit trigger levels. It turns the modem handshake lines on or off. It flushes each FIFO through its own bit.

The transmit-low flag tells the serial logic that the transmit buffer needs refilling. It is high whenever the transmit FIFO holds no more bytes than the chosen trigger level. When the modem enable bit is clear, the clear-to-send input is forced to its asserted (low) level inside the block, and the request-to-send pin is driven low. When the bit is set, both lines pass straight through.

Top module: `sfc_top`

## Requirements
- R1: After a synchronous active-low reset, reg_rdata reads 0, both counts read 0, both overflow flags read 0 and tx_low reads 1.
- R2: Control bits 5:4 choose the trigger level: 0 gives 8, 1 gives 4, 2 gives 2 and 3 gives 1. tx_low is 1 exactly when tx_count is less than or equal to that level.
- R3: Each FIFO returns bytes in the order they were pushed. A pop updates the read-data output on the clock edge that takes the pop, so the popped byte is visible in the following cycle.
- R4: An accepted push raises the count by 1 and an accepted pop lowers it by 1. A push and a pop in the same cycle on a non-empty FIFO leave the count unchanged, and this also applies when the FIFO is full. The count never exceeds 16.
- R5: A push to a full FIFO with no pop in the same cycle is dropped and sets that FIFO's sticky overflow flag. The flag stays set until reset or until that FIFO is flushed.
- R6: A pop from an empty FIFO leaves the read-data output at its previous value and the count at 0.
- R7: While control bit 2 is 1, the transmit FIFO is emptied on the next clock edge, its overflow flag is cleared and its pushes are ignored. Normal operation resumes once the bit is written back to 0. The receive FIFO is not affected.
- R8: Control bit 1 does the same for the receive FIFO, and the transmit FIFO is not affected.
- R9: When control bit 3 is 0, cts_eff_n and rts_pin_n are both 0 whatever cts_pin_n and rts_req_n are. When it is 1, cts_eff_n follows cts_pin_n and rts_pin_n follows rts_req_n.
- R10: A control write takes effect on the next clock edge. reg_rdata then returns the written byte with bits 7:6 and bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| tx_push | input | 1 | Transmit FIFO push strobe |
| tx_wdata | input | 8 | Byte pushed into the transmit FIFO |
| tx_pop | input | 1 | Transmit FIFO pop strobe |
| tx_rdata | output | 8 | Last byte popped from the transmit FIFO |
| tx_count | output | 5 | Transmit FIFO occupancy |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| tx_low | output | 1 | Transmit occupancy at or below the trigger level |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_wdata | input | 8 | Byte pushed into the receive FIFO |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| rx_rdata | output | 8 | Last byte popped from the receive FIFO |
| rx_count | output | 5 | Receive FIFO occupancy |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| cts_pin_n | input | 1 | Clear-to-send pin, active low |
| cts_eff_n | output | 1 | Clear-to-send as seen by the serial logic |
| rts_req_n | input | 1 | Request-to-send from the serial logic, active low |
| rts_pin_n | output | 1 | Request-to-send pin, active low |

## Verification
A wrong pointer or count shows up at the ports no later than the cycle after the pop that reads the bad entry. It appears either as a byte out of push order on the read-data output, or as a count that disagrees with the number of accepted pushes and pops. A wrong trigger decode or a wrong comparison shows in tx_low in the very cycle the count crosses the level, so the bench fills and drains the transmit FIFO through all 17 occupancies under each of the four trigger settings. A flush bit that is not honoured shows as a non-zero count one edge after the bit is written, or as a count that grows while the bit is still set.

// File: rtl/sfc_pkg.sv
// Package: shared constants, control-register layout and trigger decode
// for the serial FIFO control block. Assumes an 8-bit control register.
package sfc_pkg;

    localparam int CTRL_W      = 8;
    localparam int BIT_TRIG_LO = 4;   // trigger select occupies bits 5:4
    localparam int BIT_MODEM   = 3;
    localparam int BIT_TXFLUSH = 2;
    localparam int BIT_RXFLUSH = 1;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h3E;

    // Stored control fields
    typedef struct packed {
        logic [1:0] trig_sel;
        logic       modem_en;
        logic       tx_flush;
        logic       rx_flush;
    } ctrl_t;

    // Map the two-bit trigger select to a byte count
    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8;
            2'd1:    return 4;
            2'd2:    return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sfc_ctrl_reg.sv
// Control register: captures software writes and presents the stored
// fields to the FIFOs, the flag logic and the modem gating. Assumes a
// single-cycle write strobe; read-back is combinational from the stored
// fields, with unused bits returning 0.
module sfc_ctrl_reg
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;

    // Store the writable fields on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.trig_sel <= wdata[BIT_TRIG_LO+1:BIT_TRIG_LO];
            ctrl_q.modem_en <= wdata[BIT_MODEM];
            ctrl_q.tx_flush <= wdata[BIT_TXFLUSH];
            ctrl_q.rx_flush <= wdata[BIT_RXFLUSH];
        end
    end

    // Rebuild the register image for read-back
    always_comb begin
        rdata = '0;
        rdata[BIT_TRIG_LO+1:BIT_TRIG_LO] = ctrl_q.trig_sel;
        rdata[BIT_MODEM]   = ctrl_q.modem_en;
        rdata[BIT_TXFLUSH] = ctrl_q.tx_flush;
        rdata[BIT_RXFLUSH] = ctrl_q.rx_flush;
    end

    assign ctrl = ctrl_q;

    // A write becomes visible as the masked byte one edge later
    assert_readback_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == ($past(wdata) & CTRL_MASK)));

endmodule

// File: rtl/sfc_fifo.sv
// Synchronous FIFO with registered read data, a sticky overflow flag and
// a synchronous flush input. Assumes push and pop are single-cycle
// strobes. A push to a full FIFO is accepted only if a pop happens in the
// same cycle. A pop from an empty FIFO is ignored. While flush is high the
// FIFO is held empty and pushes are dropped.
module sfc_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         pop,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic              full, empty, push_ok, pop_ok;

    // Decode occupancy and qualify the strobes
    always_comb begin
        full    = (cnt_q == FULL_CNT);
        empty   = (cnt_q == '0);
        pop_ok  = pop && !empty && !flush;
        push_ok = push && !flush && (!full || pop_ok);
    end

    // Storage array write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointers, occupancy, read data and overflow tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt_q    <= '0;
            rdata    <= '0;
            overflow <= 1'b0;
        end else if (flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt_q    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
                rdata  <= mem[rd_ptr];
            end
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
            if (push && !push_ok) overflow <= 1'b1;
        end
    end

    assign count = cnt_q;

    // Occupancy never exceeds the depth
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // A lone accepted push grows the count by exactly one
    assert_push_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count != FULL_CNT) |=> (count == $past(count) + 1'b1));

    // A lone push to a full FIFO is dropped and flags overflow
    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count == FULL_CNT) |=> (count == FULL_CNT && overflow));

    // A pop on empty changes neither data nor count
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count == '0) |=> (count == '0 && $stable(rdata)));

    // Flush empties the FIFO on the next edge (R7 for transmit, R8 for receive)
    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !overflow));

endmodule

// File: rtl/sfc_tx_flag.sv
// Transmit-low flag: compares the transmit occupancy with the level
// chosen by the trigger select each cycle. Assumes DEPTH is at least 8 so
// every level is reachable. The clock and reset serve only the checks.
module sfc_tx_flag
    import sfc_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       trig_sel,
    output logic             flag
);

    logic [CNT_W-1:0] level;

    // Decode the threshold and compare it with the occupancy
    always_comb begin
        level = CNT_W'(trig_level(trig_sel));
        flag  = (count <= level);
    end

    // Above the largest level the flag is always low
    assert_flag_high_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count > CNT_W'(8)) |-> !flag);

    // At or below the smallest level the flag is always high
    assert_flag_low_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CNT_W'(1)) |-> flag);

endmodule

// File: rtl/sfc_top.sv
// Serial FIFO control top: a control register, transmit and receive
// FIFOs, the transmit trigger flag and the modem-line gating. Assumes a
// single clock domain and synchronous active-low reset. The serial
// shifter on the far side drives the pops and pushes.
module sfc_top
    import sfc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_ovf,
    output logic              tx_low,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_ovf,
    input  logic              cts_pin_n,
    output logic              cts_eff_n,
    input  logic              rts_req_n,
    output logic              rts_pin_n
);

    ctrl_t ctrl;

    sfc_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    sfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl.tx_flush),
        .push     (tx_push),
        .wdata    (tx_wdata),
        .pop      (tx_pop),
        .rdata    (tx_rdata),
        .count    (tx_count),
        .overflow (tx_ovf)
    );

    sfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (ctrl.rx_flush),
        .push     (rx_push),
        .wdata    (rx_wdata),
        .pop      (rx_pop),
        .rdata    (rx_rdata),
        .count    (rx_count),
        .overflow (rx_ovf)
    );

    sfc_tx_flag #(.CNT_W(CNT_W)) u_tx_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (tx_count),
        .trig_sel (ctrl.trig_sel),
        .flag     (tx_low)
    );

    // Gate the handshake lines with the modem enable bit
    always_comb begin
        cts_eff_n = ctrl.modem_en ? cts_pin_n : 1'b0;
        rts_pin_n = ctrl.modem_en ? rts_req_n : 1'b0;
    end

    // With modem lines disabled both lines sit at their low level
    assert_modem_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[BIT_MODEM] == 1'b0) |-> (cts_eff_n == 1'b0 && rts_pin_n == 1'b0));

endmodule

// File: tb/sfc_top_tb.sv
// Bench for sfc_top: sweeps the control read-back, every trigger setting
// across every transmit occupancy, ordering, overflow, empty pops, flushes
// and modem gating. Inputs change at the falling edge and outputs are
// sampled at the next falling edge.
module sfc_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, tx_rdata;
    logic [4:0] tx_count;
    logic       tx_ovf, tx_low;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0, rx_rdata;
    logic [4:0] rx_count;
    logic       rx_ovf;
    logic       cts_pin_n = 1'b1, rts_req_n = 1'b1;
    logic       cts_eff_n, rts_pin_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sfc_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_ovf(tx_ovf), .tx_low(tx_low),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_ovf(rx_ovf),
        .cts_pin_n(cts_pin_n), .cts_eff_n(cts_eff_n),
        .rts_req_n(rts_req_n), .rts_pin_n(rts_pin_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input int v);
        reg_wr = 1'b1; reg_wdata = 8'(v);
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic push_tx(input int b);
        tx_push = 1'b1; tx_wdata = 8'(b);
        tick();
        tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic push_rx(input int b);
        rx_push = 1'b1; rx_wdata = 8'(b);
        tick();
        rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before all checks R1 to R10 completed");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1", "reg_rdata", reg_rdata, 0);
        chk("R1", "tx_count", tx_count, 0);
        chk("R1", "rx_count", rx_count, 0);
        chk("R1", "tx_ovf", tx_ovf, 0);
        chk("R1", "rx_ovf", rx_ovf, 0);
        chk("R1", "tx_low", tx_low, 1);

        // R10: read-back sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            wr_ctrl(v);
            chk("R10", "reg_rdata", reg_rdata, v & 8'h3E);
        end
        wr_ctrl(0);
        tick();

        // R2 R3 R4 R5 R6: each trigger across every occupancy
        for (int t = 0; t < 4; t++) begin
            int lvl;
            int expc;
            lvl = 8 >> t;
            wr_ctrl((t << 4) | 4);
            tick();
            chk("R7", "tx_count after flush", tx_count, 0);
            chk("R7", "tx_ovf cleared by flush", tx_ovf, 0);
            wr_ctrl(t << 4);
            chk("R2", "tx_low at empty", tx_low, 1);
            for (int n = 1; n <= 17; n++) begin
                push_tx(n + 16 * t);
                expc = (n > 16) ? 16 : n;
                chk("R4", "tx_count on fill", tx_count, expc);
                chk("R2", "tx_low on fill", tx_low, (expc <= lvl) ? 1 : 0);
                chk("R5", "tx_ovf on fill", tx_ovf, (n > 16) ? 1 : 0);
            end
            for (int i = 1; i <= 16; i++) begin
                pop_tx();
                expc = 16 - i;
                chk("R3", "tx_rdata order", tx_rdata, (i + 16 * t) & 8'hFF);
                chk("R4", "tx_count on drain", tx_count, expc);
                chk("R2", "tx_low on drain", tx_low, (expc <= lvl) ? 1 : 0);
            end
            pop_tx();
            chk("R6", "tx_rdata after empty pop", tx_rdata, (16 + 16 * t) & 8'hFF);
            chk("R6", "tx_count after empty pop", tx_count, 0);
            chk("R5", "tx_ovf sticky", tx_ovf, 1);
        end

        // R4: simultaneous push and pop, mid-fill and full
        wr_ctrl(4);
        wr_ctrl(0);
        for (int i = 0; i < 3; i++) push_tx(8'hA0 + i);
        tx_push = 1'b1; tx_wdata = 8'hA3; tx_pop = 1'b1;
        tick();
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R4", "count after push+pop", tx_count, 3);
        chk("R3", "data on push+pop", tx_rdata, 8'hA0);
        for (int i = 0; i < 13; i++) push_tx(8'hB0 + i);
        chk("R4", "count full", tx_count, 16);
        tx_push = 1'b1; tx_wdata = 8'hCC; tx_pop = 1'b1;
        tick();
        tx_push = 1'b0; tx_pop = 1'b0;
        chk("R4", "count full push+pop", tx_count, 16);
        chk("R5", "no overflow on full push+pop", tx_ovf, 0);
        chk("R3", "data full push+pop", tx_rdata, 8'hA1);

        // R3 R6: receive ordering with a computed pattern
        for (int i = 0; i < 16; i++) push_rx((i * 7 + 3) & 8'hFF);
        chk("R4", "rx_count full", rx_count, 16);
        push_rx(8'hEE);
        chk("R5", "rx_ovf", rx_ovf, 1);
        for (int i = 0; i < 16; i++) begin
            pop_rx();
            chk("R3", "rx_rdata order", rx_rdata, (i * 7 + 3) & 8'hFF);
        end
        pop_rx();
        chk("R6", "rx_rdata after empty pop", rx_rdata, (15 * 7 + 3) & 8'hFF);
        chk("R6", "rx_count after empty pop", rx_count, 0);

        // R8: receive flush holds empty, transmit untouched
        for (int i = 0; i < 5; i++) push_rx(8'h40 + i);
        wr_ctrl(2);
        chk("R8", "rx_count before flush edge", rx_count, 5);
        tick();
        chk("R8", "rx_count flushed", rx_count, 0);
        chk("R8", "rx_ovf cleared", rx_ovf, 0);
        chk("R8", "tx_count untouched", tx_count, 16);
        push_rx(8'h77);
        chk("R8", "rx push ignored while flushing", rx_count, 0);
        wr_ctrl(0);
        push_rx(8'h55);
        chk("R8", "rx resumes", rx_count, 1);
        pop_rx();
        chk("R8", "rx data after resume", rx_rdata, 8'h55);

        // R7: transmit flush holds empty, receive untouched
        push_rx(8'h66);
        wr_ctrl(4);
        tick();
        chk("R7", "tx_count flushed", tx_count, 0);
        chk("R7", "rx_count untouched", rx_count, 1);
        push_tx(8'h12);
        chk("R7", "tx push ignored while flushing", tx_count, 0);
        wr_ctrl(0);
        push_tx(8'h34);
        chk("R7", "tx resumes", tx_count, 1);
        pop_tx();
        chk("R7", "tx data after resume", tx_rdata, 8'h34);

        // R9: modem gating, disabled then enabled
        for (int c = 0; c < 4; c++) begin
            cts_pin_n = c[0]; rts_req_n = c[1];
            #1;
            chk("R9", "cts_eff_n disabled", cts_eff_n, 0);
            chk("R9", "rts_pin_n disabled", rts_pin_n, 0);
        end
        wr_ctrl(8);
        for (int c = 0; c < 4; c++) begin
            cts_pin_n = c[0]; rts_req_n = c[1];
            #1;
            chk("R9", "cts_eff_n enabled", cts_eff_n, c & 1);
            chk("R9", "rts_pin_n enabled", rts_pin_n, (c >> 1) & 1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule